// File: doc/BRIEF.md
# Coarse-and-Vernier Hit Timestamp

This block stamps a single pixel hit with a time finer than the reference period. A free-running coarse counter advances once per reference period. A fast local oscillator runs at an integer multiple of the reference rate and drives a one-hot ring, which marks each reference boundary. When a hit is sampled, a vernier counter starts and counts fast ticks until the next reference boundary, then stops. The stopped coarse value, scaled by the tick ratio, minus the vernier count gives the hit time in fast-tick units, truncated to the time field width.

The result goes into a fixed-width hit record with the pixel address. A completed record is presented for exactly one reference period. The cell takes one hit at a time: once armed, it ignores further hits until its record has been shown or a clear aborts it. Records of this form are meant to be stored during a bunch train and drained during the gap between trains, which happens outside this block.

The oscillator is an input clock (`osc_clk`). Its ring is taken as phase-locked to the reference, so the first ring position after reset marks a reference boundary. `rst_n` is asserted asynchronously and must be released in step with `osc_clk`.

Top module: `hit_time_stamper`

## Requirements
- R1: While `rst_n` is low, `rec_valid_o` is 0 and `rec_data_o` is all zeros.
- R2: For a hit sampled at the N-th rising edge of `osc_clk` after reset release, the record time field `rec_data_o[10:0]` equals N modulo 2048. This is coarse × 14 − fine, with fine in 0..13 counting ticks from the sampling edge to the next reference boundary.
- R3: `rec_data_o[31:16]` holds the value `pix_addr_i` had at the edge that sampled the hit.
- R4: `rec_data_o[15:11]` is zero in every record.
- R5: A record is shown for exactly 14 oscillator cycles, one reference period. It starts in the cycle after the first reference boundary at or after the hit edge. Reference boundaries are the edges whose count since reset is a multiple of 14.
- R6: Hits that arrive while a measurement runs or a record is shown are ignored. The shown record stays unchanged, and no second record follows.
- R7: `clear_i` high at an edge drops `rec_valid_o` in the next cycle and cancels any running measurement, so no record appears for that hit. `clear_i` wins over a simultaneous hit.
- R8: The time field wraps modulo 2048 without disturbing the tick phase.
- R9: While `rec_valid_o` is 0, `rec_data_o` is all zeros.
- R10: A hit sampled exactly at a reference boundary gives fine = 0 and is shown right after that edge. A hit sampled right after a boundary gives fine = 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock, 14 ticks per reference period |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| hit_i | input | 1 | Hit indication from the pixel front end |
| clear_i | input | 1 | Aborts a running measurement or a shown record |
| pix_addr_i | input | 16 | Pixel address to store in the record |
| rec_valid_o | output | 1 | High for one reference period while a record is shown |
| rec_data_o | output | 32 | Hit record: address [31:16], zeros [15:11], time [10:0] |

## Verification
The bench builds the block with its default parameters: 14 ticks per reference period, a 16-bit address, an 11-bit time field and a 32-bit record. The bench oscillator runs at 125 MHz, so the time field wraps after 2048 ticks, about 16 µs. Wrap cases near and across that point can therefore be driven within a short run. Because the ratio is 14, hits can be placed on every ring phase, including both vernier extremes: a hit on the boundary itself and a hit just after it.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_RUN  = 2'd1,
    VS_SHOW = 2'd2
  } vstate_e;
endpackage

// File: rtl/ts_phase_ring.sv
module ts_phase_ring #(
  parameter int TICKS = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap_o
);
  logic [TICKS-1:0] ring_q;
  logic [TICKS-1:0] ring_d;

  for (genvar i = 0; i < TICKS; i++) begin : g_rot
    if (i == 0) begin : g_head
      assign ring_d[i] = ring_q[TICKS-1];
    end else begin : g_body
      assign ring_d[i] = ring_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= TICKS'(1);
    else        ring_q <= ring_d;
  end

  assign wrap_o = ring_q[TICKS-1];
endmodule

// File: rtl/ts_coarse_ctr.sv
module ts_coarse_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign next_o = cnt_q + W'(1);
  assign cnt_en = step_i;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ts_vernier_ctl.sv
module ts_vernier_ctl
  import ts_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int COARSE_W = 11,
  parameter int FINE_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_i,
  input  logic                clear_i,
  input  logic                wrap_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [COARSE_W-1:0] coarse_next_i,
  output logic                show_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o
);
  vstate_e             st_q, st_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [COARSE_W-1:0] crs_q, crs_d;
  logic [FINE_W-1:0]   fine_q, fine_d;
  logic                addr_en, crs_en, fine_en;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    crs_d   = crs_q;
    fine_d  = fine_q;
    addr_en = 1'b0;
    crs_en  = 1'b0;
    fine_en = 1'b0;
    unique case (st_q)
      VS_IDLE: begin
        if (hit_i && !clear_i) begin
          addr_en = 1'b1;
          addr_d  = addr_i;
          fine_en = 1'b1;
          fine_d  = '0;
          if (wrap_i) begin
            crs_en = 1'b1;
            crs_d  = coarse_next_i;
            st_d   = VS_SHOW;
          end else begin
            st_d   = VS_RUN;
          end
        end
      end
      VS_RUN: begin
        if (clear_i) begin
          st_d = VS_IDLE;
        end else begin
          fine_en = 1'b1;
          fine_d  = fine_q + FINE_W'(1);
          if (wrap_i) begin
            crs_en = 1'b1;
            crs_d  = coarse_next_i;
            st_d   = VS_SHOW;
          end
        end
      end
      VS_SHOW: begin
        if (clear_i || wrap_i) st_d = VS_IDLE;
      end
      default: st_d = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= VS_IDLE;
      addr_q <= '0;
      crs_q  <= '0;
      fine_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_en) addr_q <= addr_d;
      if (crs_en)  crs_q  <= crs_d;
      if (fine_en) fine_q <= fine_d;
    end
  end

  assign show_o   = (st_q == VS_SHOW);
  assign addr_o   = addr_q;
  assign coarse_o = crs_q;
  assign fine_o   = fine_q;
endmodule

// File: rtl/ts_record_pack.sv
module ts_record_pack #(
  parameter int TICKS  = 14,
  parameter int ADDR_W = 16,
  parameter int TIME_W = 11,
  parameter int FINE_W = 4,
  parameter int REC_W  = 32
) (
  input  logic              show_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TIME_W-1:0] coarse_i,
  input  logic [FINE_W-1:0] fine_i,
  output logic [REC_W-1:0]  rec_o
);
  localparam int RSV_W = REC_W - ADDR_W - TIME_W;
  localparam logic [TIME_W-1:0] SCALE = TIME_W'(TICKS);

  logic [TIME_W-1:0] scaled;
  logic [TIME_W-1:0] fine_ext;
  logic [TIME_W-1:0] stamp;

  assign scaled   = coarse_i * SCALE;
  assign fine_ext = {{(TIME_W-FINE_W){1'b0}}, fine_i};
  assign stamp    = scaled - fine_ext;

  always_comb begin
    rec_o = '0;
    if (show_i) rec_o = {addr_i, {RSV_W{1'b0}}, stamp};
  end
endmodule

// File: rtl/hit_time_stamper.sv
module hit_time_stamper #(
  parameter int TICKS  = 14,
  parameter int ADDR_W = 16,
  parameter int TIME_W = 11,
  parameter int REC_W  = 32
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] pix_addr_i,
  output logic              rec_valid_o,
  output logic [REC_W-1:0]  rec_data_o
);
  localparam int FINE_W   = $clog2(TICKS);
  localparam int COARSE_W = TIME_W;

  logic                ref_wrap;
  logic [COARSE_W-1:0] coarse_next;
  logic                show;
  logic [ADDR_W-1:0]   held_addr;
  logic [COARSE_W-1:0] held_coarse;
  logic [FINE_W-1:0]   held_fine;

  ts_phase_ring #(.TICKS(TICKS)) ring_i (
    .clk    (osc_clk),
    .rst_n  (rst_n),
    .wrap_o (ref_wrap)
  );

  ts_coarse_ctr #(.W(COARSE_W)) coarse_i (
    .clk    (osc_clk),
    .rst_n  (rst_n),
    .step_i (ref_wrap),
    .next_o (coarse_next)
  );

  ts_vernier_ctl #(
    .ADDR_W   (ADDR_W),
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
  ) vern_i (
    .clk           (osc_clk),
    .rst_n         (rst_n),
    .hit_i         (hit_i),
    .clear_i       (clear_i),
    .wrap_i        (ref_wrap),
    .addr_i        (pix_addr_i),
    .coarse_next_i (coarse_next),
    .show_o        (show),
    .addr_o        (held_addr),
    .coarse_o      (held_coarse),
    .fine_o        (held_fine)
  );

  ts_record_pack #(
    .TICKS  (TICKS),
    .ADDR_W (ADDR_W),
    .TIME_W (TIME_W),
    .FINE_W (FINE_W),
    .REC_W  (REC_W)
  ) pack_i (
    .show_i   (show),
    .addr_i   (held_addr),
    .coarse_i (held_coarse),
    .fine_i   (held_fine),
    .rec_o    (rec_data_o)
  );

  assign rec_valid_o = show;
endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int TICKS  = 14,
  parameter int ADDR_W = 16,
  parameter int TIME_W = 11,
  parameter int REC_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             wrap,
  input logic             rec_valid_o,
  input logic [REC_W-1:0] rec_data_o
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (rec_valid_o) run_q <= run_q + CW'(1);
    else                  run_q <= '0;
  end

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> (rec_data_o[REC_W-ADDR_W-1:TIME_W] == '0));

  assert_quiet_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid_o |-> (rec_data_o == '0));

  assert_show_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> (run_q < CW'(TICKS)));

  assert_show_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_valid_o && $past(rec_valid_o) && !$past(clear_i))
      |-> ($past(run_q) == CW'(TICKS - 1)));

  assert_show_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid_o) |-> $past(wrap));

  assert_record_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && $past(rec_valid_o)) |-> $stable(rec_data_o));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !rec_valid_o);
endmodule

bind hit_time_stamper ts_checker #(
  .TICKS  (TICKS),
  .ADDR_W (ADDR_W),
  .TIME_W (TIME_W),
  .REC_W  (REC_W)
) chk_i (
  .clk         (osc_clk),
  .rst_n       (rst_n),
  .clear_i     (clear_i),
  .wrap        (ref_wrap),
  .rec_valid_o (rec_valid_o),
  .rec_data_o  (rec_data_o)
);

// File: tb/hit_time_stamper_tb_top.sv
`timescale 1ns/1ps
module hit_time_stamper_tb_top;
  localparam int TICKS = 14;

  logic        clk;
  logic        rst_n;
  logic        hit_i;
  logic        clear_i;
  logic [15:0] pix_addr_i;
  logic        rec_valid_o;
  logic [31:0] rec_data_o;

  int n_checks;
  int n_fail;
  int edge_cnt;
  bit done;

  hit_time_stamper dut_i (
    .osc_clk     (clk),
    .rst_n       (rst_n),
    .hit_i       (hit_i),
    .clear_i     (clear_i),
    .pix_addr_i  (pix_addr_i),
    .rec_valid_o (rec_valid_o),
    .rec_data_o  (rec_data_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rec_valid_o) seen = 1;
    end
    chk(!seen, req, "no record expected", 32'(seen), 32'd0);
  endtask

  // Arm at phase p once edge_cnt >= min_k; returns capture edge number.
  task automatic fire(input int p, input int min_k, input logic [15:0] addr,
                      output int cap);
    @(negedge clk);
    while (edge_cnt < min_k || (edge_cnt % TICKS) != p || rec_valid_o) @(negedge clk);
    hit_i = 1'b1;
    pix_addr_i = addr;
    @(negedge clk);
    hit_i = 1'b0;
    cap = edge_cnt;
  endtask

  task automatic measure(input int p, input int min_k, input logic [15:0] addr,
                         input string req);
    int cap, s;
    fire(p, min_k, addr, cap);
    s = ((cap + TICKS - 1) / TICKS) * TICKS;
    while (edge_cnt < s) begin
      chk(!rec_valid_o, "R5", "early record", 32'(rec_valid_o), 32'd0);
      @(negedge clk);
    end
    chk(rec_valid_o == 1'b1, "R5", "record start", 32'(rec_valid_o), 32'd1);
    chk(rec_data_o[10:0] == 11'(cap % 2048), req, "time field",
        32'(rec_data_o[10:0]), 32'(cap % 2048));
    chk(rec_data_o[31:16] == addr, "R3", "address field",
        32'(rec_data_o[31:16]), 32'(addr));
    chk(rec_data_o[15:11] == 5'd0, "R4", "reserved bits",
        32'(rec_data_o[15:11]), 32'd0);
    while (edge_cnt < s + TICKS - 1) @(negedge clk);
    chk(rec_valid_o == 1'b1, "R5", "record last cycle", 32'(rec_valid_o), 32'd1);
    @(negedge clk);
    chk(rec_valid_o == 1'b0, "R5", "record end", 32'(rec_valid_o), 32'd0);
    chk(rec_data_o == 32'd0, "R9", "data when idle", rec_data_o, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; hit_i = 1'b0; clear_i = 1'b0; pix_addr_i = 16'h0;
    edge_cnt = 0;
    repeat (3) @(negedge clk);
    hit_i = 1'b1;
    @(negedge clk);
    chk(rec_valid_o == 1'b0, "R1", "valid in reset", 32'(rec_valid_o), 32'd0);
    chk(rec_data_o == 32'd0, "R1", "data in reset", rec_data_o, 32'd0);
    hit_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_phases;
    measure(5, 0, 16'hA5C3, "R2");
    measure(13, 0, 16'h0001, "R10");   // fine = 0, boundary hit
    measure(0, 0, 16'hFFFF, "R10");    // fine = 13
    measure(7, 0, 16'h1234, "R2");
  endtask

  task automatic t_ignore;
    int cap, s;
    fire(2, 0, 16'hBEEF, cap);
    s = ((cap + TICKS - 1) / TICKS) * TICKS;
    hit_i = 1'b1; pix_addr_i = 16'h4444;
    repeat (3) @(negedge clk);
    hit_i = 1'b0;
    while (edge_cnt < s + 3) @(negedge clk);
    hit_i = 1'b1; pix_addr_i = 16'h7777;
    @(negedge clk);
    hit_i = 1'b0;
    chk(rec_data_o[31:16] == 16'hBEEF, "R6", "first address kept",
        32'(rec_data_o[31:16]), 32'hBEEF);
    chk(rec_data_o[10:0] == 11'(cap % 2048), "R6", "first time kept",
        32'(rec_data_o[10:0]), 32'(cap % 2048));
    while (edge_cnt < s + TICKS) @(negedge clk);
    quiet(30, "R6");
  endtask

  task automatic t_clear;
    int cap;
    fire(3, 0, 16'h2222, cap);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    quiet(40, "R7");
    fire(13, 0, 16'h3333, cap);
    chk(rec_valid_o == 1'b1, "R7", "shown before clear", 32'(rec_valid_o), 32'd1);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    chk(rec_valid_o == 1'b0, "R7", "clear drops record", 32'(rec_valid_o), 32'd0);
    while ((edge_cnt % TICKS) != 4) @(negedge clk);
    clear_i = 1'b1; hit_i = 1'b1; pix_addr_i = 16'h5555;
    @(negedge clk);
    clear_i = 1'b0; hit_i = 1'b0;
    quiet(30, "R7");
    measure(9, 0, 16'h6666, "R7");
  endtask

  task automatic t_wrap;
    measure(5, 2044, 16'h0F0F, "R8");
    measure(13, 2100, 16'hF0F0, "R8");
    measure(1, 4090, 16'h8001, "R8");
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    t_reset;
    t_phases;
    t_ignore;
    t_clear;
    t_wrap;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule